// File: doc/BRIEF.md
# Receive Event Status and Interrupt Register

This block sits between a receive-side frame controller and a host register port. The controller delivers single-cycle event pulses. The block turns each pulse into a sticky status bit that the host must service. The controller also supplies a handful of level conditions. These go to a second register that always shows the present state and keeps no history.

A third register holds one enable bit per sticky event. An active-low interrupt line is pulled low while any enabled sticky bit is set and has not yet been read by the host. Reading the sticky register releases the interrupt contribution of every bit that was read as one. The bits themselves stay set until the host writes ones to them. A fresh event on a bit that is already set, even one already read, raises the interrupt again.

Host access uses a small synchronous port with an address, a write enable, a read enable and a data word. Read data comes back registered, one clock after the read request.

Top module: `lsr_status_block`

## Requirements
- R1: After reset, all sticky bits and all enable bits are zero, `irq_n_o` is high and `rd_data_o` is zero.
- R2: An event pulse on `evt_i[i]` sets sticky bit i at the next clock edge. The bit then stays set with no further pulses, and reading it does not change it.
- R3: A write to address 1 clears sticky bit i for every i where `wr_data_i[i]` is one. Bits written with zero keep their value.
- R4: A read of address 0 returns `live_i` in bits RT_W-1:0, with zeros above, as sampled at the read edge. Writes to address 0 change no state.
- R5: A write to address 2 loads the enable register. A read of address 2 returns it. Enable bit i = 1 lets sticky bit i reach the interrupt.
- R6: `irq_n_o` goes low right after the clock edge that latches an event on an enabled bit. Events on disabled bits leave it high.
- R7: A read of address 1 that returns sticky bit i as one drops that bit's interrupt contribution after the read edge. `irq_n_o` then returns high unless another enabled, set and unread bit remains, including one set by an event in that same cycle.
- R8: When an event on bit i and a write-one-to-clear of bit i fall in the same cycle, the bit ends set and counts as unread.
- R9: A new event on a sticky bit that is already set and already read marks it unread again, and re-asserts the interrupt if it is enabled.
- R10: `rd_data_o` is loaded at the clock edge that samples `rd_en_i` and holds its value between reads. Address 3 reads as zero. A read in the same cycle as a write returns the value from before the write.
- R11: Setting an enable bit for a sticky bit that is set and unread pulls `irq_n_o` low after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | N | Single-cycle event pulses from the receiver |
| live_i | input | RT_W | Real-time condition levels |
| addr_i | input | 2 | Register address: 0 live, 1 sticky, 2 enable |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wr_data_i | input | N | Write data |
| rd_data_o | output | N | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The hardest states to reach from the ports are the collisions inside one clock. These are an event arriving in the same cycle as a write-one-to-clear of that bit, or in the same cycle as the read that would release the interrupt. Other hard cases involve a bit that is already set and already read. The vector table places these collisions on exact cycles: it drives the event together with the write or the read on one edge. It then reads the register back on the next step, so the outcome shows on both the interrupt line and the read data. A mid-run reset after pending events checks that every register returns to its start value.

// File: rtl/lsr_pkg.sv
// Shared constants and types for the latched status block.
// Assumes a two-bit register address space.
package lsr_pkg;
    localparam int ADDR_W = 2;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t ADDR_LIVE  = 2'd0;
    localparam reg_addr_t ADDR_EVENT = 2'd1;
    localparam reg_addr_t ADDR_MASK  = 2'd2;
endpackage

// File: rtl/lsr_latch_bank.sv
// Sticky event bits, each with a read-since-set flag.
// Per bit, an event wins over a clear, and a clear wins over a read mark.
// Assumes events are single-cycle pulses in the clk domain.
module lsr_latch_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    input  logic         rd_mark_i,
    output logic [N-1:0] lat_q,
    output logic [N-1:0] seen_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Update one sticky bit and its read flag by priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q[i]  <= 1'b0;
                seen_q[i] <= 1'b0;
            end else if (evt_i[i]) begin
                lat_q[i]  <= 1'b1;
                seen_q[i] <= 1'b0;
            end else if (clr_i[i]) begin
                lat_q[i]  <= 1'b0;
                seen_q[i] <= 1'b0;
            end else if (rd_mark_i && lat_q[i]) begin
                seen_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsr_mask_reg.sv
// Interrupt enable register with one bit per sticky event.
// Resets to all disabled.
module lsr_mask_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_q
);
    // Load the whole enable word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_i) begin
            mask_q <= wdata_i;
        end
    end
endmodule

// File: rtl/lsr_irq_gen.sv
// Active-low interrupt built from set, enabled and unread sticky bits.
// All inputs come from flops, so the output does not glitch on bus activity.
module lsr_irq_gen #(
    parameter int N = 8
) (
    input  logic [N-1:0] lat_i,
    input  logic [N-1:0] seen_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_n_o
);
    logic [N-1:0] pend;

    // Find the bits that still call for service.
    always_comb begin
        pend    = lat_i & mask_i & ~seen_i;
        irq_n_o = ~(|pend);
    end
endmodule

// File: rtl/lsr_read_port.sv
// Registered read multiplexer. Data appears one clock after the request.
// Assumes RT_W <= N. Live bits are zero-extended.
module lsr_read_port #(
    parameter int N    = 8,
    parameter int RT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  lsr_pkg::reg_addr_t addr_i,
    input  logic [RT_W-1:0]   live_i,
    input  logic [N-1:0]      lat_i,
    input  logic [N-1:0]      mask_i,
    output logic [N-1:0]      rd_data_o
);
    logic [N-1:0] sel;

    // Pick the addressed register. Unmapped addresses give zero.
    always_comb begin
        sel = '0;
        case (addr_i)
            lsr_pkg::ADDR_LIVE:  sel[RT_W-1:0] = live_i;
            lsr_pkg::ADDR_EVENT: sel = lat_i;
            lsr_pkg::ADDR_MASK:  sel = mask_i;
            default:             sel = '0;
        endcase
    end

    // Capture the selection on a read and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= sel;
        end
    end
endmodule

// File: rtl/lsr_status_block.sv
// Top level: sticky event status, live status, interrupt enables and an
// active-low interrupt behind a simple synchronous register port.
// Assumes the host port and event sources share clk.
module lsr_status_block #(
    parameter int N    = 8,
    parameter int RT_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              evt_i,
    input  logic [RT_W-1:0]           live_i,
    input  logic [lsr_pkg::ADDR_W-1:0] addr_i,
    input  logic                      wr_en_i,
    input  logic                      rd_en_i,
    input  logic [N-1:0]              wr_data_i,
    output logic [N-1:0]              rd_data_o,
    output logic                      irq_n_o
);
    logic [N-1:0] lat_q;
    logic [N-1:0] seen_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] clr_vec;
    logic         rd_mark;
    logic         mask_wr;

    // Decode the host strobes into per-register controls.
    always_comb begin
        clr_vec = (wr_en_i && addr_i == lsr_pkg::ADDR_EVENT) ? wr_data_i : '0;
        rd_mark = rd_en_i && (addr_i == lsr_pkg::ADDR_EVENT);
        mask_wr = wr_en_i && (addr_i == lsr_pkg::ADDR_MASK);
    end

    lsr_latch_bank #(.N(N)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_vec),
        .rd_mark_i(rd_mark),
        .lat_q    (lat_q),
        .seen_q   (seen_q)
    );

    lsr_mask_reg #(.N(N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mask_wr),
        .wdata_i(wr_data_i),
        .mask_q (mask_q)
    );

    lsr_irq_gen #(.N(N)) u_irq (
        .lat_i  (lat_q),
        .seen_i (seen_q),
        .mask_i (mask_q),
        .irq_n_o(irq_n_o)
    );

    lsr_read_port #(.N(N), .RT_W(RT_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .live_i   (live_i),
        .lat_i    (lat_q),
        .mask_i   (mask_q),
        .rd_data_o(rd_data_o)
    );
endmodule

// File: rtl/lsr_status_checker.sv
// Protocol checks for lsr_status_block, attached with bind.
module lsr_status_checker #(
    parameter int N = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N-1:0]               evt_i,
    input logic [lsr_pkg::ADDR_W-1:0] addr_i,
    input logic                       wr_en_i,
    input logic                       rd_en_i,
    input logic [N-1:0]               wr_data_i,
    input logic [N-1:0]               rd_data_o,
    input logic                       irq_n_o,
    input logic [N-1:0]               lat_q,
    input logic [N-1:0]               mask_q
);
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((lat_q & $past(evt_i)) == $past(evt_i))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|evt_i) && !wr_en_i) |=> (lat_q == $past(lat_q))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == lsr_pkg::ADDR_EVENT)
        |=> ((lat_q & $past(wr_data_i) & ~$past(evt_i)) == '0)); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & wr_data_i)) && wr_en_i && addr_i == lsr_pkg::ADDR_EVENT)
        |=> ((lat_q & $past(evt_i & wr_data_i)) == $past(evt_i & wr_data_i))); // R8

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == lsr_pkg::ADDR_MASK) |=> (mask_q == $past(wr_data_i))); // R5

    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & mask_q)) && !(wr_en_i && addr_i == lsr_pkg::ADDR_MASK))
        |=> !irq_n_o); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> irq_n_o); // R6

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == lsr_pkg::ADDR_MASK) |=> (rd_data_o == $past(mask_q))); // R10
endmodule

bind lsr_status_block lsr_status_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o),
    .irq_n_o  (irq_n_o),
    .lat_q    (lat_q),
    .mask_q   (mask_q)
);

// File: tb/lsr_status_block_test.sv
`timescale 1ns/1ps
module lsr_status_block_test;
    localparam int N    = 8;
    localparam int RT_W = 4;
    localparam int NV   = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    evt = '0;
    logic [RT_W-1:0] live = '0;
    logic [1:0]      addr = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [N-1:0]    wdata = '0;
    logic [N-1:0]    rdata;
    logic            irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lsr_status_block #(.N(N), .RT_W(RT_W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .live_i(live), .addr_i(addr),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .wr_data_i(wdata),
        .rd_data_o(rdata), .irq_n_o(irq_n)
    );

    // Vector layout: op[33:32] (0 idle, 1 read, 2 write, 3 read+write),
    // addr[31:30], wdata[29:22], evt[21:14], live[13:10],
    // check-read[9], expected read[8:1], expected irq_n[0].
    localparam logic [33:0] VEC [NV] = '{
        {2'd2, 2'd2, 8'h0F, 8'h00, 4'h0, 1'b0, 8'h00, 1'b1},
        {2'd0, 2'd0, 8'h00, 8'h01, 4'h0, 1'b0, 8'h00, 1'b0},
        {2'd1, 2'd1, 8'h00, 8'h00, 4'h0, 1'b1, 8'h01, 1'b1},
        {2'd1, 2'd1, 8'h00, 8'h00, 4'h0, 1'b1, 8'h01, 1'b1},
        {2'd0, 2'd0, 8'h00, 8'h10, 4'h0, 1'b0, 8'h00, 1'b1},
        {2'd1, 2'd2, 8'h00, 8'h00, 4'h0, 1'b1, 8'h0F, 1'b1},
        {2'd2, 2'd2, 8'h1F, 8'h00, 4'h0, 1'b0, 8'h00, 1'b0},
        {2'd2, 2'd1, 8'h10, 8'h00, 4'h0, 1'b0, 8'h00, 1'b1},
        {2'd1, 2'd1, 8'h00, 8'h00, 4'h0, 1'b1, 8'h01, 1'b1},
        {2'd0, 2'd0, 8'h00, 8'h01, 4'h0, 1'b0, 8'h00, 1'b0},
        {2'd2, 2'd1, 8'h01, 8'h01, 4'h0, 1'b0, 8'h00, 1'b0},
        {2'd1, 2'd1, 8'h00, 8'h00, 4'h0, 1'b1, 8'h01, 1'b1},
        {2'd2, 2'd1, 8'h01, 8'h00, 4'h0, 1'b0, 8'h00, 1'b1},
        {2'd1, 2'd1, 8'h00, 8'h00, 4'h0, 1'b1, 8'h00, 1'b1},
        {2'd3, 2'd0, 8'hFF, 8'h00, 4'hA, 1'b1, 8'h0A, 1'b1},
        {2'd1, 2'd0, 8'h00, 8'h00, 4'h5, 1'b1, 8'h05, 1'b1},
        {2'd1, 2'd3, 8'h00, 8'h00, 4'h0, 1'b1, 8'h00, 1'b1},
        {2'd0, 2'd0, 8'h00, 8'h03, 4'h0, 1'b0, 8'h00, 1'b0},
        {2'd1, 2'd1, 8'h00, 8'h02, 4'h0, 1'b1, 8'h03, 1'b0},
        {2'd1, 2'd1, 8'h00, 8'h00, 4'h0, 1'b1, 8'h03, 1'b1}
    };

    function automatic string tag_of(int idx);
        case (idx)
            0, 5:           return "R5";
            1, 4, 17:       return "R6";
            2, 18, 19:      return "R7";
            3:              return "R2";
            6:              return "R11";
            7, 8, 12, 13:   return "R3";
            9:              return "R9";
            10, 11:         return "R8";
            14, 15:         return "R4";
            default:        return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then sample just after the edge.
    task automatic step(logic [1:0] op, logic [1:0] a, logic [N-1:0] wd,
                        logic [N-1:0] ev, logic [RT_W-1:0] lv);
        rd_en = op[0];
        wr_en = op[1];
        addr  = a;
        wdata = wd;
        evt   = ev;
        live  = lv;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        wr_en = 1'b0;
        evt   = '0;
        wdata = '0;
        live  = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state at the ports.
        check("R1 irq_n", 32'(irq_n), 32'd1);
        check("R1 rd_data", 32'(rdata), 32'd0);
        step(2'd1, 2'd2, '0, '0, '0);
        check("R1 enable", 32'(rdata), 32'd0);
        step(2'd1, 2'd1, '0, '0, '0);
        check("R1 sticky", 32'(rdata), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            step(v[33:32], v[31:30], v[29:22], v[21:14], v[13:10]);
            check(tag_of(i), 32'(irq_n), 32'(v[0]));
            if (v[9]) check(tag_of(i), 32'(rdata), 32'(v[8:1]));
        end

        // R10: read data holds across idle cycles.
        step(2'd0, 2'd1, '0, '0, 4'hF);
        step(2'd2, 2'd2, 8'h55, '0, '0);
        check("R10 hold", 32'(rdata), 32'h03);

        // R1: mid-run reset with an enabled event pending.
        step(2'd2, 2'd2, 8'hFF, '0, '0);
        step(2'd0, 2'd0, '0, 8'h04, '0);
        check("R6 pending", 32'(irq_n), 32'd0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 irq after reset", 32'(irq_n), 32'd1);
        check("R1 rd after reset", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        step(2'd1, 2'd1, '0, '0, '0);
        check("R1 sticky after reset", 32'(rdata), 32'd0);
        step(2'd1, 2'd2, '0, '0, '0);
        check("R1 enable after reset", 32'(rdata), 32'd0);

        finish_run();
    end
endmodule